// File: doc/BRIEF.md
# ATA Host DMA Command Sequencer

This block runs one DMA read or DMA write command against an ATA device from issue to completion. A local controller presents a command with its direction, feature byte, sector count, sector number, cylinder and device/head byte. The sequencer arms its DMA channel, programs the device's task-file registers over a simple byte-wide register bus, and issues the command opcode. Data words then move between the device and a local stream while the device requests transfer.

The device may request transfer in bursts of any length. For a write, words come from a valid/ready source stream. For a read, words go to a valid/ready sink stream. A word moves only in a cycle where the device requests it and the local stream side can take part. The sequencer expects exactly one interrupt, after the whole transfer. An interrupt that comes earlier is treated as an error. After the interrupt the channel is disarmed, Status is read, and Error is read only when Status reports a failure. A programmable watchdog ends a command that makes no progress.

Top module: `ata_dma_seq`

## Requirements
- R1: The channel-armed output `chan_arm` rises before the first task-file write of a command and stays high during every task-file write.
- R2: Task-file writes occur in this order, with these addresses: feature (1), sector count (2), sector number (3), cylinder low byte (4), cylinder high byte (5), device/head (6). The command write to address 7 comes last. Its opcode is 8'hC8 for a read and 8'hCA for a write (`cmd_write`=1).
- R3: A word moves (`dack` high) only in a cycle where `dmarq` is high and the stream side is ready. For a write this means `src_valid` high, with `dev_wdata` equal to `src_data`. For a read it means `snk_ready` high, with `snk_data` equal to `dev_rdata`. Transfers may pause and resume any number of times.
- R4: The command moves exactly sector count × 256 words. A sector count of 0 means 256 sectors, which is 65536 words.
- R5: An `intrq` that arrives before the last word has moved ends the transfer and sets `err`.
- R6: After the last word, the sequencer waits for `intrq` before it disarms the channel and reads Status. No interrupt is required between sectors.
- R7: Status (read address 7) is read only while `chan_arm` is low, after the channel has been disarmed.
- R8: Error (read address 1) is read in the cycle after the Status read, and only when Status bit 0 is set. In that case `err` is 1 and `err_code` holds the Error value. Otherwise `err_code` is 0.
- R9: If neither a word nor the interrupt arrives for `wdog_limit` consecutive cycles during the transfer or the wait for the interrupt, the command is aborted. `done` then comes with `timeout`=1 and `err`=1, the channel is disarmed, and no task-file read takes place.
- R10: After reset, `cmd_ready`=1 and `chan_arm`, `tf_wr`, `tf_rd`, `dack` and `done` are 0. `cmd_ready` is high only while no command is active. While `cmd_ready` is high there are no bus strobes and no data moves. `done` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Sequencer idle, command accepted when valid |
| cmd_write | input | 1 | 1 = DMA write, 0 = DMA read |
| cmd_features | input | 8 | Feature byte |
| cmd_count | input | 8 | Sector count (0 = 256) |
| cmd_sector | input | 8 | Sector number |
| cmd_cylinder | input | 16 | Cylinder |
| cmd_devhead | input | 8 | Device/head byte |
| wdog_limit | input | 24 | Cycles without progress before abort |
| tf_wr | output | 1 | Task-file write strobe |
| tf_rd | output | 1 | Task-file read strobe |
| tf_addr | output | 3 | Task-file register address |
| tf_wdata | output | 8 | Task-file write data |
| tf_rdata | input | 8 | Task-file read data, valid with tf_rd |
| chan_arm | output | 1 | DMA channel armed |
| dmarq | input | 1 | Device transfer request |
| dack | output | 1 | One word moves this cycle |
| intrq | input | 1 | Device interrupt |
| dev_wdata | output | 16 | Word to device (write) |
| dev_rdata | input | 16 | Word from device (read) |
| src_valid | input | 1 | Source word valid |
| src_ready | output | 1 | Source word taken |
| src_data | input | 16 | Source word |
| snk_valid | output | 1 | Sink word valid |
| snk_ready | input | 1 | Sink can accept |
| snk_data | output | 16 | Sink word |
| done | output | 1 | Command finished (one cycle) |
| err | output | 1 | Command failed, valid with done |
| timeout | output | 1 | Watchdog abort, valid with done |
| err_code | output | 8 | Error register value, valid with done |

## Verification
Strobes and stream handshakes are combinational from the sequencer state and inputs. The bench therefore records `dack`, `tf_wr` and `tf_rd` at each rising edge in a device model and compares the logs only once `done` is seen. The first parameter write follows acceptance by two edges, because arming takes one cycle. Each later write follows one edge apart. The command write is followed by data in the next cycle in which `dmarq` and the stream agree. `done` is registered one cycle after the last Status or Error read, or one cycle after disarming on timeout. `err`, `timeout` and `err_code` are sampled on the falling edge while `done` is high, and an interrupt held back three cycles after the last word shows that completion waits for it.

// File: rtl/ata_dma_pkg.sv
package ata_dma_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ARM,
        S_PARAM,
        S_CMD,
        S_XFER,
        S_WAIT_INT,
        S_DISARM,
        S_RD_STAT,
        S_RD_ERR,
        S_DONE
    } seq_state_e;

    // task-file addresses decoded by the device
    localparam logic [2:0] TF_FEAT    = 3'd1;
    localparam logic [2:0] TF_COUNT   = 3'd2;
    localparam logic [2:0] TF_SECTOR  = 3'd3;
    localparam logic [2:0] TF_CYL_LO  = 3'd4;
    localparam logic [2:0] TF_CYL_HI  = 3'd5;
    localparam logic [2:0] TF_DEVHD   = 3'd6;
    localparam logic [2:0] TF_CMD     = 3'd7;
    localparam logic [2:0] TF_STATUS  = 3'd7;
    localparam logic [2:0] TF_ERROR   = 3'd1;

    localparam logic [7:0] OP_DMA_READ  = 8'hC8;
    localparam logic [7:0] OP_DMA_WRITE = 8'hCA;

    localparam int unsigned PARAM_WRITES = 6;

    typedef struct packed {
        logic        write;
        logic [7:0]  feat;
        logic [7:0]  count;
        logic [7:0]  sector;
        logic [15:0] cyl;
        logic [7:0]  devhd;
    } cmd_t;

endpackage

// File: rtl/ata_dma_wordcnt.sv
module ata_dma_wordcnt #(
    parameter int unsigned SECT_WORDS = 256,
    parameter int unsigned CNT_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             dec_i,
    output logic             last_o
);
    localparam int unsigned WC_W = $clog2(SECT_WORDS * (2 ** CNT_W)) + 1;

    logic [WC_W-1:0] rem_d, rem_q;
    logic [WC_W-1:0] sectors;

    always_comb begin
        sectors = (count_i == '0) ? (WC_W'(1) << CNT_W) : WC_W'(count_i);
        rem_d   = rem_q;
        if (load_i) begin
            rem_d = sectors * WC_W'(SECT_WORDS);
        end else if (dec_i && rem_q != '0) begin
            rem_d = rem_q - WC_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rem_q <= '0;
        else        rem_q <= rem_d;
    end

    assign last_o = (rem_q == WC_W'(1));
endmodule

// File: rtl/ata_dma_wdog.sv
module ata_dma_wdog #(
    parameter int unsigned WDOG_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              run_i,
    input  logic [WDOG_W-1:0] limit_i,
    output logic              expired_o
);
    logic [WDOG_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i)                  cnt_d = '0;
        else if (run_i && ~&cnt_q)    cnt_d = cnt_q + WDOG_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = run_i && !clear_i && (cnt_q >= limit_i);
endmodule

// File: rtl/ata_dma_seq.sv
module ata_dma_seq
    import ata_dma_pkg::*;
#(
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned SECT_WORDS = 256,
    parameter int unsigned CNT_W      = 8,
    parameter int unsigned WDOG_W     = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [7:0]        cmd_features,
    input  logic [CNT_W-1:0]  cmd_count,
    input  logic [7:0]        cmd_sector,
    input  logic [15:0]       cmd_cylinder,
    input  logic [7:0]        cmd_devhead,
    input  logic [WDOG_W-1:0] wdog_limit,
    output logic              tf_wr,
    output logic              tf_rd,
    output logic [2:0]        tf_addr,
    output logic [7:0]        tf_wdata,
    input  logic [7:0]        tf_rdata,
    output logic              chan_arm,
    input  logic              dmarq,
    output logic              dack,
    input  logic              intrq,
    output logic [DATA_W-1:0] dev_wdata,
    input  logic [DATA_W-1:0] dev_rdata,
    input  logic              src_valid,
    output logic              src_ready,
    input  logic [DATA_W-1:0] src_data,
    output logic              snk_valid,
    input  logic              snk_ready,
    output logic [DATA_W-1:0] snk_data,
    output logic              done,
    output logic              err,
    output logic              timeout,
    output logic [7:0]        err_code
);
    localparam int unsigned PIDX_W = $clog2(PARAM_WRITES);

    typedef struct packed {
        seq_state_e        st;
        cmd_t              cmd;
        logic [PIDX_W-1:0] pidx;
        logic              armed;
        logic              err;
        logic              tout;
        logic [7:0]        ecode;
    } regs_t;

    regs_t r_d, r_q;

    logic xfer, wc_load, wc_last, wd_clear, wd_run, wd_expired;

    ata_dma_wordcnt #(
        .SECT_WORDS (SECT_WORDS),
        .CNT_W      (CNT_W)
    ) i_wordcnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (wc_load),
        .count_i (cmd_count),
        .dec_i   (xfer),
        .last_o  (wc_last)
    );

    ata_dma_wdog #(
        .WDOG_W (WDOG_W)
    ) i_wdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (wd_clear),
        .run_i     (wd_run),
        .limit_i   (wdog_limit),
        .expired_o (wd_expired)
    );

    always_comb begin
        r_d      = r_q;
        tf_wr    = 1'b0;
        tf_rd    = 1'b0;
        tf_addr  = '0;
        tf_wdata = '0;
        xfer     = 1'b0;
        wc_load  = 1'b0;
        wd_clear = 1'b0;
        wd_run   = 1'b0;

        unique case (r_q.st)
            S_IDLE: begin
                if (cmd_valid) begin
                    r_d.cmd.write  = cmd_write;
                    r_d.cmd.feat   = cmd_features;
                    r_d.cmd.count  = 8'(cmd_count);
                    r_d.cmd.sector = cmd_sector;
                    r_d.cmd.cyl    = cmd_cylinder;
                    r_d.cmd.devhd  = cmd_devhead;
                    r_d.err        = 1'b0;
                    r_d.tout       = 1'b0;
                    r_d.ecode      = '0;
                    wc_load        = 1'b1;
                    r_d.st         = S_ARM;
                end
            end
            S_ARM: begin
                // channel goes live before any register is touched
                r_d.armed = 1'b1;
                r_d.pidx  = '0;
                r_d.st    = S_PARAM;
            end
            S_PARAM: begin
                tf_wr = 1'b1;
                case (r_q.pidx)
                    PIDX_W'(0): begin tf_addr = TF_FEAT;   tf_wdata = r_q.cmd.feat;       end
                    PIDX_W'(1): begin tf_addr = TF_COUNT;  tf_wdata = r_q.cmd.count;      end
                    PIDX_W'(2): begin tf_addr = TF_SECTOR; tf_wdata = r_q.cmd.sector;     end
                    PIDX_W'(3): begin tf_addr = TF_CYL_LO; tf_wdata = r_q.cmd.cyl[7:0];   end
                    PIDX_W'(4): begin tf_addr = TF_CYL_HI; tf_wdata = r_q.cmd.cyl[15:8];  end
                    default:    begin tf_addr = TF_DEVHD;  tf_wdata = r_q.cmd.devhd;      end
                endcase
                if (r_q.pidx == PIDX_W'(PARAM_WRITES - 1)) r_d.st = S_CMD;
                else                                       r_d.pidx = r_q.pidx + PIDX_W'(1);
            end
            S_CMD: begin
                tf_wr    = 1'b1;
                tf_addr  = TF_CMD;
                tf_wdata = r_q.cmd.write ? OP_DMA_WRITE : OP_DMA_READ;
                wd_clear = 1'b1;
                r_d.st   = S_XFER;
            end
            S_XFER: begin
                wd_run = 1'b1;
                if (intrq) begin
                    // interrupt before the final word: premature completion
                    r_d.err = 1'b1;
                    r_d.st  = S_DISARM;
                end else begin
                    xfer = dmarq && (r_q.cmd.write ? src_valid : snk_ready);
                    if (xfer) begin
                        wd_clear = 1'b1;
                        if (wc_last) r_d.st = S_WAIT_INT;
                    end else if (wd_expired) begin
                        r_d.err  = 1'b1;
                        r_d.tout = 1'b1;
                        r_d.st   = S_DISARM;
                    end
                end
            end
            S_WAIT_INT: begin
                wd_run = 1'b1;
                if (intrq) begin
                    r_d.st = S_DISARM;
                end else if (wd_expired) begin
                    r_d.err  = 1'b1;
                    r_d.tout = 1'b1;
                    r_d.st   = S_DISARM;
                end
            end
            S_DISARM: begin
                r_d.armed = 1'b0;
                r_d.st    = r_q.tout ? S_DONE : S_RD_STAT;
            end
            S_RD_STAT: begin
                tf_rd   = 1'b1;
                tf_addr = TF_STATUS;
                if (tf_rdata[0]) begin
                    r_d.err = 1'b1;
                    r_d.st  = S_RD_ERR;
                end else begin
                    r_d.st  = S_DONE;
                end
            end
            S_RD_ERR: begin
                tf_rd     = 1'b1;
                tf_addr   = TF_ERROR;
                r_d.ecode = tf_rdata;
                r_d.st    = S_DONE;
            end
            S_DONE: begin
                r_d.st = S_IDLE;
            end
            default: begin
                r_d.st    = S_IDLE;
                r_d.armed = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= S_IDLE;
        end else begin
            r_q       <= r_d;
        end
    end

    assign cmd_ready = (r_q.st == S_IDLE);
    assign done      = (r_q.st == S_DONE);
    assign err       = r_q.err;
    assign timeout   = r_q.tout;
    assign err_code  = r_q.ecode;
    assign chan_arm  = r_q.armed;
    assign dack      = xfer;
    assign src_ready = xfer && r_q.cmd.write;
    assign snk_valid = xfer && !r_q.cmd.write;
    assign dev_wdata = src_data;
    assign snk_data  = dev_rdata;
endmodule

// File: rtl/ata_dma_seq_chk.sv
module ata_dma_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_ready,
    input logic       tf_wr,
    input logic       tf_rd,
    input logic [2:0] tf_addr,
    input logic       chan_arm,
    input logic       dmarq,
    input logic       dack,
    input logic       src_ready,
    input logic       src_valid,
    input logic       snk_valid,
    input logic       snk_ready,
    input logic       done
);
    a_r1_armed_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        tf_wr |-> chan_arm);

    a_r7_disarmed_on_status: assert property (@(posedge clk) disable iff (!rst_n)
        tf_rd |-> !chan_arm);

    a_r3_dack_needs_dmarq: assert property (@(posedge clk) disable iff (!rst_n)
        dack |-> dmarq);

    a_r3_stream_agrees: assert property (@(posedge clk) disable iff (!rst_n)
        dack |-> ((src_ready && src_valid) || (snk_valid && snk_ready)));

    a_r8_error_after_status: assert property (@(posedge clk) disable iff (!rst_n)
        (tf_rd && tf_addr == 3'd1) |-> $past(tf_rd && tf_addr == 3'd7));

    a_r10_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!tf_wr && !tf_rd && !dack && !chan_arm));

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({tf_wr, tf_rd, dack}) <= 1);
endmodule

bind ata_dma_seq ata_dma_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_ready (cmd_ready),
    .tf_wr     (tf_wr),
    .tf_rd     (tf_rd),
    .tf_addr   (tf_addr),
    .chan_arm  (chan_arm),
    .dmarq     (dmarq),
    .dack      (dack),
    .src_ready (src_ready),
    .src_valid (src_valid),
    .snk_valid (snk_valid),
    .snk_ready (snk_ready),
    .done      (done)
);

// File: tb/test_ata_dma_seq.sv
module test_ata_dma_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_ready, cmd_write = 1'b0;
    logic [7:0]  cmd_features = '0, cmd_count = '0, cmd_sector = '0, cmd_devhead = '0;
    logic [15:0] cmd_cylinder = '0;
    logic [23:0] wdog_limit = 24'd40;
    logic        tf_wr, tf_rd, chan_arm, dmarq, dack, intrq;
    logic [2:0]  tf_addr;
    logic [7:0]  tf_wdata, tf_rdata, err_code;
    logic [15:0] dev_wdata, dev_rdata, src_data, snk_data;
    logic        src_valid, src_ready, snk_valid, snk_ready, done, err, timeout;

    always #5 clk = ~clk;

    ata_dma_seq i_ata_dma_seq (.*);

    // device and stream model configuration (driven by the main process)
    logic       cfg_bursty = 1'b0, cfg_early = 1'b0, cfg_mute = 1'b0;
    int         cfg_target = 0;
    logic [7:0] cfg_stat = 8'h50, cfg_ecode = 8'h00;
    localparam int EARLY_AT = 100;

    // model state
    int          cyc = 0, words = 0, int_dly = 0, src_idx = 0, snk_idx = 0;
    int          mism = 0, wr_n = 0, rd_n = 0, wr_unarmed = 0, rd_armed = 0;
    int          last_dack = 0, cmd_cyc = 0;
    logic        dev_active = 1'b0, intrq_q = 1'b0;
    logic [2:0]  wr_addr [0:7];
    logic [7:0]  wr_data [0:7];
    logic [2:0]  rd_addr [0:3];

    assign intrq     = intrq_q;
    assign dmarq     = dev_active && !intrq_q && (words < cfg_target)
                       && !(cfg_early && words >= EARLY_AT)
                       && (cfg_bursty ? (cyc % 8 < 4) : 1'b1);
    assign src_valid = cfg_bursty ? (cyc % 3 != 0) : 1'b1;
    assign snk_ready = cfg_bursty ? (cyc % 3 != 1) : 1'b1;
    assign src_data  = 16'(src_idx) ^ 16'hA5A5;
    assign dev_rdata = 16'(words) + 16'h1000;
    assign tf_rdata  = (tf_addr == 3'd7) ? cfg_stat : (tf_addr == 3'd1) ? cfg_ecode : 8'h00;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cmd_valid && cmd_ready) begin
            wr_n <= 0; rd_n <= 0; wr_unarmed <= 0; rd_armed <= 0; mism <= 0;
            src_idx <= 0; snk_idx <= 0; words <= 0;
        end
        if (tf_wr) begin
            if (wr_n < 8) begin wr_addr[wr_n] <= tf_addr; wr_data[wr_n] <= tf_wdata; end
            wr_n <= wr_n + 1;
            if (!chan_arm) wr_unarmed <= wr_unarmed + 1;
            if (tf_addr == 3'd7) begin
                cmd_cyc <= cyc;
                if (!cfg_mute) begin dev_active <= 1'b1; words <= 0; int_dly <= 0; end
            end
        end
        if (tf_rd) begin
            if (rd_n < 4) rd_addr[rd_n] <= tf_addr;
            rd_n <= rd_n + 1;
            if (chan_arm) rd_armed <= rd_armed + 1;
            if (tf_addr == 3'd7) begin intrq_q <= 1'b0; dev_active <= 1'b0; end
        end
        if (dack) begin
            words <= words + 1;
            last_dack <= cyc;
            if (cmd_write && dev_wdata != (16'(words) ^ 16'hA5A5)) mism <= mism + 1;
        end
        if (src_valid && src_ready) src_idx <= src_idx + 1;
        if (snk_valid && snk_ready) begin
            snk_idx <= snk_idx + 1;
            if (snk_data != 16'(snk_idx) + 16'h1000) mism <= mism + 1;
        end
        if (dev_active && !intrq_q && !tf_rd) begin
            if (cfg_early && words >= EARLY_AT) intrq_q <= 1'b1;
            else if (words >= cfg_target) begin
                if (int_dly == 3) intrq_q <= 1'b1;
                else int_dly <= int_dly + 1;
            end
        end
    end

    int n_chk = 0, n_fail = 0;

    task automatic check(input logic ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    typedef struct packed {
        logic       wr;
        logic [7:0] cnt;
        logic [7:0] stat;
        logic [7:0] ecode;
        logic       early;
        logic       bursty;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'd1, 8'h50, 8'h00, 1'b0, 1'b0},
        '{1'b1, 8'd2, 8'h50, 8'h00, 1'b0, 1'b1},
        '{1'b0, 8'd3, 8'h51, 8'h04, 1'b0, 1'b1},
        '{1'b1, 8'd1, 8'h50, 8'h00, 1'b1, 1'b0},
        '{1'b0, 8'd0, 8'h51, 8'h10, 1'b0, 1'b0}
    };

    // returns 1 when done was seen
    task automatic issue(input logic wr, input logic [7:0] cnt, input int idx, output logic seen,
                         output logic busy_ok);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_write = wr; cmd_count = cnt;
        cmd_features = 8'(idx); cmd_sector = 8'h11;
        cmd_cylinder = 16'h1234 + 16'(idx); cmd_devhead = 8'hE0;
        @(negedge clk);
        cmd_valid = 1'b0;
        busy_ok = !cmd_ready;
        seen = 1'b0;
        for (int k = 0; k < 80000 && !seen; k++) begin
            if (done) seen = 1'b1;
            else @(negedge clk);
        end
    endtask

    initial begin
        logic seen, busy_ok;
        int   exp_words;
        logic exp_err;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(cmd_ready === 1'b1, "R10 ready after reset", cmd_ready, 1);
        check({chan_arm, tf_wr, tf_rd, dack, done} === 5'b0, "R10 quiet after reset",
              {chan_arm, tf_wr, tf_rd, dack, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            cfg_bursty = VECS[v].bursty; cfg_early = VECS[v].early; cfg_mute = 1'b0;
            cfg_stat = VECS[v].stat; cfg_ecode = VECS[v].ecode;
            cfg_target = (VECS[v].cnt == 0 ? 256 : int'(VECS[v].cnt)) * 256;
            exp_words  = VECS[v].early ? EARLY_AT : cfg_target;
            exp_err    = VECS[v].early | VECS[v].stat[0];
            issue(VECS[v].wr, VECS[v].cnt, v, seen, busy_ok);
            check(seen, "R6 done reached", seen, 1);
            check(busy_ok, "R10 not ready while busy", !busy_ok, 0);
            check(err === exp_err, "R5/R8 err flag", err, exp_err);
            check(timeout === 1'b0, "R9 no timeout", timeout, 0);
            check(wr_unarmed == 0, "R1 writes while armed", wr_unarmed, 0);
            check(wr_n == 7, "R2 write count", wr_n, 7);
            for (int i = 0; i < 7; i++)
                check(wr_addr[i] == 3'(i + 1), "R2 write order", wr_addr[i], i + 1);
            check(wr_data[0] == 8'(v) && wr_data[1] == VECS[v].cnt && wr_data[2] == 8'h11
                  && wr_data[3] == 8'h34 + 8'(v) && wr_data[4] == 8'h12 && wr_data[5] == 8'hE0,
                  "R2 parameter values", {wr_data[0], wr_data[1], wr_data[3]},
                  {8'(v), VECS[v].cnt, 8'h34 + 8'(v)});
            check(wr_data[6] == (VECS[v].wr ? 8'hCA : 8'hC8), "R2 opcode", wr_data[6],
                  VECS[v].wr ? 8'hCA : 8'hC8);
            check(words == exp_words, "R4 word count", words, exp_words);
            check(mism == 0, "R3 data order", mism, 0);
            check(rd_armed == 0 && rd_n >= 1 && rd_addr[0] == 3'd7, "R7 status read disarmed",
                  rd_armed, 0);
            check(rd_n == (VECS[v].stat[0] ? 2 : 1), "R8 error read only on bit0", rd_n,
                  VECS[v].stat[0] ? 2 : 1);
            check(err_code == (VECS[v].stat[0] ? VECS[v].ecode : 8'h00), "R8 err_code", err_code,
                  VECS[v].stat[0] ? VECS[v].ecode : 8'h00);
            if (!VECS[v].early)
                check(cyc - last_dack >= 5, "R6 waits for interrupt", cyc - last_dack, 5);
            @(negedge clk);
            check(!done && cmd_ready, "R10 done is a pulse", done, 0);
        end

        // R9: device never requests data
        cfg_mute = 1'b1; cfg_bursty = 1'b0; cfg_early = 1'b0; cfg_target = 256;
        wdog_limit = 24'd20;
        issue(1'b0, 8'd1, 9, seen, busy_ok);
        check(seen && timeout === 1'b1 && err === 1'b1, "R9 timeout flagged", {timeout, err}, 2'b11);
        check(rd_n == 0, "R9 no task-file read", rd_n, 0);
        check(!chan_arm, "R9 channel disarmed", chan_arm, 0);
        check(words == 0, "R9 no data moved", words, 0);
        check(cyc - cmd_cyc >= 20, "R9 waited the limit", cyc - cmd_cyc, 20);
        @(negedge clk);
        check(cmd_ready === 1'b1, "R10 idle after abort", cmd_ready, 1);
        finish_run();
    end
endmodule